// File: doc/BRIEF.md
# Mixed-sign byte dot-product accumulator

This block forms one output element of an integer matrix product. Each operation takes two 32-bit source words, each split into four 8-bit lanes, and a 32-bit running sum. It multiplies lane i of the first word by lane i of the second word, adds the four products to the running sum, and returns the new 32-bit sum. A controller outside the block walks the rows and columns and feeds the result back as the next `acc_in`.

Each source has its own signedness control. The two control bits give four lane interpretations: signed by signed, signed by unsigned, unsigned by signed and unsigned by unsigned. The datapath has two register stages and a fixed latency. A new operation can enter on every clock cycle, and results leave in the order the operations entered.

Top module: `byte_dot_acc`

## Requirements
- R1: Lane i of a source word occupies bits [8i+7:8i], so lane 0 is bits [7:0] and lane 3 is bits [31:24]. Each lane of `src_a` is multiplied only by the lane of `src_b` with the same index.
- R2: When `a_signed` is 1, every lane of `src_a` is read as a two's-complement value from -128 to 127. When it is 0, every lane is read as an unsigned value from 0 to 255.
- R3: `b_signed` selects the reading of the `src_b` lanes in the same way as R2, independently of `a_signed`.
- R4: Each of the four products is extended to 32 bits without loss. The result is `acc_in` plus the sum of the four products.
- R5: The sum wraps modulo 2^32, with no saturation and no overflow indication.
- R6: `out_valid` rises exactly two clock edges after an edge that samples `in_valid` high, and `acc_out` then carries the result of that operation.
- R7: An operation can be accepted on every cycle, with the signedness modes changing from cycle to cycle. Results appear in the order the operations were accepted.
- R8: While `out_valid` is low, `acc_out` keeps its last value. Inputs sampled while `in_valid` is low have no effect on the outputs.
- R9: A clock edge with `rst_n` low clears `out_valid` and `acc_out` to 0 and discards every operation still in the pipeline.
- R10: With both modes unsigned and every byte 0xFF, the block adds 260100 to `acc_in`. With both modes signed and every byte 0x80, it adds 65536.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | An operation is presented this cycle |
| a_signed | input | 1 | 1: lanes of `src_a` are signed; 0: unsigned |
| b_signed | input | 1 | 1: lanes of `src_b` are signed; 0: unsigned |
| src_a | input | 32 | First source word, four byte lanes |
| src_b | input | 32 | Second source word, four byte lanes |
| acc_in | input | 32 | Running sum to add into |
| out_valid | output | 1 | `acc_out` holds a new result |
| acc_out | output | 32 | Updated running sum |

## Verification
A new operation can be accepted in the same cycle that an earlier operation's result leaves the block, and the two may use different signedness modes. The bench provokes this by issuing operations back to back for long stretches. On every cycle of those stretches it draws the two mode bits and all data at random, and it breaks some stretches with bubbles. Each result is judged against an in-order queue of expected values, computed from the lane rules, two cycles after the operation was issued. A mode that leaked from a neighbouring operation, or a result that slipped by one cycle, therefore shows up as a mismatch.

// File: rtl/bdot_pkg.sv
`timescale 1ns/1ps
// Package bdot_pkg
// Purpose : Default geometry and a few shared helpers for the byte
//           dot-product accumulator.
// Assumes : The product width derived here fits inside the accumulator.
package bdot_pkg;

    localparam int DEF_LANES  = 4;
    localparam int DEF_LANE_W = 8;
    localparam int DEF_ACC_W  = 32;

    // Width of one lane product: each operand widened by one bit for the sign.
    function automatic int prod_width(input int lane_w);
        return 2 * lane_w + 2;
    endfunction

    // Signedness selection for one operation.
    typedef struct packed {
        logic a_sgn;
        logic b_sgn;
    } sign_mode_t;

endpackage

// File: rtl/bdot_lane_mul.sv
`timescale 1ns/1ps
// Module  : bdot_lane_mul
// Purpose : Multiplies one lane of each source. Each operand is read as
//           signed or unsigned according to its own control bit. The
//           product is sign-extended to the accumulator width.
// Assumes : OUT_W >= 2*LANE_W+2; purely combinational.
module bdot_lane_mul #(
    parameter int LANE_W = 8,
    parameter int OUT_W  = 32
) (
    input  logic [LANE_W-1:0] a_lane,
    input  logic [LANE_W-1:0] b_lane,
    input  logic              a_sgn,
    input  logic              b_sgn,
    output logic [OUT_W-1:0]  prod
);
    localparam int EXT_W  = LANE_W + 1;
    localparam int PROD_W = 2 * LANE_W + 2;
    localparam int PAD_W  = OUT_W - PROD_W;

    logic signed [EXT_W-1:0]  a_ext;
    logic signed [EXT_W-1:0]  b_ext;
    logic signed [PROD_W-1:0] p_raw;

    // Widen each lane by one bit: copy the top bit when signed, else a zero.
    always_comb begin
        a_ext = {a_sgn & a_lane[LANE_W-1], a_lane};
        b_ext = {b_sgn & b_lane[LANE_W-1], b_lane};
    end

    // Signed multiply of the widened lanes; the result width is exact.
    always_comb begin
        p_raw = PROD_W'(a_ext) * PROD_W'(b_ext);
    end

    // Sign-extend the product to the accumulator width.
    generate
        if (PAD_W > 0) begin : g_pad
            assign prod = {{PAD_W{p_raw[PROD_W-1]}}, p_raw};
        end else begin : g_nopad
            assign prod = p_raw[OUT_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/bdot_sum_tree.sv
`timescale 1ns/1ps
// Module  : bdot_sum_tree
// Purpose : Adds N terms to a base value, wrapping modulo 2^W. With a
//           power-of-two N it uses a balanced tree; otherwise it uses a
//           linear chain.
// Assumes : Purely combinational; terms are already extended to W bits.
module bdot_sum_tree #(
    parameter int N = 4,
    parameter int W = 32
) (
    input  logic [N-1:0][W-1:0] terms,
    input  logic [W-1:0]        base,
    output logic [W-1:0]        total
);
    localparam bit POW2 = (N > 1) && ((N & (N - 1)) == 0);

    generate
        if (POW2) begin : g_tree
            localparam int LVL = $clog2(N);
            // Node storage: level l holds N>>l partial sums.
            logic [LVL:0][N-1:0][W-1:0] node;
            assign node[0] = terms;
            for (genvar l = 1; l <= LVL; l++) begin : g_lvl
                for (genvar j = 0; j < N; j++) begin : g_node
                    if (j < (N >> l)) begin : g_add
                        // Pairwise addition of the level below.
                        assign node[l][j] = node[l-1][2*j] + node[l-1][2*j+1];
                    end else begin : g_zero
                        assign node[l][j] = '0;
                    end
                end
            end
            // Fold the reduced products into the base.
            assign total = base + node[LVL][0];
        end else begin : g_chain
            // Linear accumulation for lane counts that are not a power of two.
            always_comb begin
                total = base;
                for (int i = 0; i < N; i++) begin
                    total = total + terms[i];
                end
            end
        end
    endgenerate

endmodule

// File: rtl/bdot_pipe_reg.sv
`timescale 1ns/1ps
// Module  : bdot_pipe_reg
// Purpose : Pipeline register with a load enable; it clears to zero on a
//           synchronous active-low reset.
// Assumes : Holds its value whenever en is low.
module bdot_pipe_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Capture d on enable; reset wins over enable.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (en) q <= d;
    end
endmodule

// File: rtl/byte_dot_acc.sv
`timescale 1ns/1ps
// Module  : byte_dot_acc
// Purpose : Four-lane byte dot product added into a 32-bit running sum.
//           Each source has its own signedness. Stage 1 registers the
//           extended lane products and acc_in; stage 2 reduces them and
//           registers the sum. The latency is two cycles and an operation
//           can enter every cycle.
// Assumes : Synchronous active-low reset; the sum wraps modulo 2^ACC_W.
module byte_dot_acc #(
    parameter int LANES  = bdot_pkg::DEF_LANES,
    parameter int LANE_W = bdot_pkg::DEF_LANE_W,
    parameter int ACC_W  = bdot_pkg::DEF_ACC_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    a_signed,
    input  logic                    b_signed,
    input  logic [LANES*LANE_W-1:0] src_a,
    input  logic [LANES*LANE_W-1:0] src_b,
    input  logic [ACC_W-1:0]        acc_in,
    output logic                    out_valid,
    output logic [ACC_W-1:0]        acc_out
);
    localparam int S1_W = LANES * ACC_W + ACC_W;

    bdot_pkg::sign_mode_t mode;
    logic [LANES-1:0][ACC_W-1:0] prod_c;
    logic [LANES-1:0][ACC_W-1:0] prod_q;
    logic [ACC_W-1:0]            acc_q;
    logic [S1_W-1:0]             s1_d;
    logic [S1_W-1:0]             s1_q;
    logic                        s1_valid;
    logic [ACC_W-1:0]            sum_c;

    // Group the two signedness controls.
    assign mode = '{a_sgn: a_signed, b_sgn: b_signed};

    // One multiplier per lane pair.
    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            bdot_lane_mul #(.LANE_W(LANE_W), .OUT_W(ACC_W)) mul_i (
                .a_lane (src_a[i*LANE_W +: LANE_W]),
                .b_lane (src_b[i*LANE_W +: LANE_W]),
                .a_sgn  (mode.a_sgn),
                .b_sgn  (mode.b_sgn),
                .prod   (prod_c[i])
            );
        end
    endgenerate

    // Stage 1 data: the extended products and the incoming sum.
    assign s1_d = {prod_c, acc_in};

    bdot_pipe_reg #(.W(S1_W)) s1_data_i (
        .clk (clk), .rst_n (rst_n), .en (in_valid), .d (s1_d), .q (s1_q)
    );

    bdot_pipe_reg #(.W(1)) s1_vld_i (
        .clk (clk), .rst_n (rst_n), .en (1'b1), .d (in_valid), .q (s1_valid)
    );

    // Split the stage-1 register back into its fields.
    assign prod_q = s1_q[S1_W-1:ACC_W];
    assign acc_q  = s1_q[ACC_W-1:0];

    // Reduce the products and fold them into the sum.
    bdot_sum_tree #(.N(LANES), .W(ACC_W)) sum_i (
        .terms (prod_q), .base (acc_q), .total (sum_c)
    );

    // Stage 2: the result register holds its value between valid results.
    bdot_pipe_reg #(.W(ACC_W)) s2_data_i (
        .clk (clk), .rst_n (rst_n), .en (s1_valid), .d (sum_c), .q (acc_out)
    );

    bdot_pipe_reg #(.W(1)) s2_vld_i (
        .clk (clk), .rst_n (rst_n), .en (1'b1), .d (s1_valid), .q (out_valid)
    );

endmodule

// File: rtl/byte_dot_acc_chk.sv
`timescale 1ns/1ps
// Module  : byte_dot_acc_chk
// Purpose : Temporal checks on the ports of byte_dot_acc, bound to every
//           instance of it.
// Assumes : Sees the same clock and reset as the block.
module byte_dot_acc_chk #(
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    parameter int ACC_W  = 32
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic                    a_signed,
    input logic                    b_signed,
    input logic [LANES*LANE_W-1:0] src_a,
    input logic [LANES*LANE_W-1:0] src_b,
    input logic [ACC_W-1:0]        acc_in,
    input logic                    out_valid,
    input logic [ACC_W-1:0]        acc_out
);
    logic [1:0] warm;

    // Count the cycles since reset, saturating at two.
    always_ff @(posedge clk) begin
        if (!rst_n)         warm <= '0;
        else if (warm != 2) warm <= warm + 2'd1;
    end

    // Model of the result, written from the lane rules.
    function automatic logic [ACC_W-1:0] model(
        input logic [LANES*LANE_W-1:0] a, input logic [LANES*LANE_W-1:0] b,
        input logic sa, input logic sb, input logic [ACC_W-1:0] acc);
        logic [ACC_W-1:0] r;
        logic signed [ACC_W-1:0] x, y;
        r = acc;
        for (int i = 0; i < LANES; i++) begin
            x = sa ? ACC_W'($signed(a[i*LANE_W +: LANE_W])) : ACC_W'(a[i*LANE_W +: LANE_W]);
            y = sb ? ACC_W'($signed(b[i*LANE_W +: LANE_W])) : ACC_W'(b[i*LANE_W +: LANE_W]);
            r = r + ACC_W'(x * y);
        end
        return r;
    endfunction

    // R6
    lat_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2) |-> (out_valid == ($past(in_valid, 2) && $past(rst_n, 2) && $past(rst_n, 1))));

    // R4
    result_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((warm == 2) && out_valid) |->
        (acc_out == model($past(src_a, 2), $past(src_b, 2), $past(a_signed, 2),
                          $past(b_signed, 2), $past(acc_in, 2))));

    // R8
    hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((warm == 2) && !out_valid && $past(rst_n)) |-> $stable(acc_out));

    // R9
    reset_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!out_valid && (acc_out == '0)));

    // R10
    uu_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((warm == 2) && out_valid && !$past(a_signed, 2) && !$past(b_signed, 2)) |->
        ((acc_out - $past(acc_in, 2)) <= ACC_W'(260100)));

    // R2
    ss_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((warm == 2) && out_valid && $past(a_signed, 2) && $past(b_signed, 2)) |->
        (($signed(acc_out - $past(acc_in, 2)) <= 65536) &&
         ($signed(acc_out - $past(acc_in, 2)) >= -65024)));

endmodule

bind byte_dot_acc byte_dot_acc_chk #(.LANES(LANES), .LANE_W(LANE_W), .ACC_W(ACC_W)) chk_i (.*);

// File: tb/byte_dot_acc_tb_top.sv
`timescale 1ns/1ps
module byte_dot_acc_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        a_signed = 1'b0;
    logic        b_signed = 1'b0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic [31:0] acc_in = '0;
    logic        out_valid;
    logic [31:0] acc_out;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Expected pipeline contents: index 1 is the oldest operation.
    bit          hv [2];
    logic [31:0] hr [2];
    string       hl [2];
    logic [31:0] last_out;
    int unsigned seed_v;

    always #2 clk = ~clk;

    byte_dot_acc dut_i (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid),
        .a_signed (a_signed), .b_signed (b_signed),
        .src_a (src_a), .src_b (src_b), .acc_in (acc_in),
        .out_valid (out_valid), .acc_out (acc_out)
    );

    // Expected result from the lane rules (R1..R5).
    function automatic logic [31:0] ref_dot(input logic [31:0] a, input logic [31:0] b,
                                            input bit sa, input bit sb, input logic [31:0] acc);
        int s;
        int x, y;
        s = int'(acc);
        for (int i = 0; i < 4; i++) begin
            x = sa ? int'($signed(a[8*i +: 8])) : int'(a[8*i +: 8]);
            y = sb ? int'($signed(b[8*i +: 8])) : int'(b[8*i +: 8]);
            s = s + x * y;
        end
        return s;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp_v);
        end
    endtask

    // One cycle: judge the outputs, then present the next operation.
    task automatic step(input bit v, input logic [31:0] a, input logic [31:0] b,
                        input bit sa, input bit sb, input logic [31:0] acc, input string req);
        @(negedge clk);
        check("R6", {31'd0, out_valid}, {31'd0, hv[1]});
        if (hv[1]) begin
            check(hl[1], acc_out, hr[1]);
            last_out = hr[1];
        end else begin
            check("R8", acc_out, last_out);
        end
        hv[1] = hv[0]; hr[1] = hr[0]; hl[1] = hl[0];
        hv[0] = v;     hr[0] = ref_dot(a, b, sa, sb, acc); hl[0] = req;
        in_valid = v; src_a = a; src_b = b; a_signed = sa; b_signed = sb; acc_in = acc;
    endtask

    task automatic apply_reset(input string req);
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b1; src_a = 32'h1234_5678; acc_in = 32'h55;
        @(negedge clk);
        check(req, {31'd0, out_valid}, 32'd0);
        check(req, acc_out, 32'd0);
        rst_n = 1'b1; in_valid = 1'b0;
        hv[0] = 0; hv[1] = 0; last_out = '0;
    endtask

    task automatic drain();
        for (int i = 0; i < 3; i++) step(0, $urandom(), $urandom(), 0, 0, $urandom(), "R8");
    endtask

    initial begin
        seed_v = $urandom(32'd2024);
        hv[0] = 0; hv[1] = 0; hl[0] = ""; hl[1] = ""; last_out = '0;
        repeat (3) @(negedge clk);
        // R9: reset state after the first reset
        apply_reset("R9");

        // R1: a single nonzero lane pair at each index; other lanes are cross-zero
        for (int i = 0; i < 4; i++)
            step(1, 32'h3 << (8*i), (32'h5 << (8*i)) | (32'h7 << (8*((i+1)%4))), 0, 0, 32'd100, "R1");
        drain();

        // R2: 0xFF in the first source is -1 when signed, 255 when not
        step(1, 32'h0000_00FF, 32'h0000_0002, 1, 0, 32'd10, "R2");
        step(1, 32'h0000_00FF, 32'h0000_0002, 0, 0, 32'd10, "R2");
        // R3: the same for the second source
        step(1, 32'h0000_0002, 32'h0000_00FF, 0, 1, 32'd10, "R3");
        step(1, 32'h0000_0002, 32'h0000_00FF, 0, 0, 32'd10, "R3");
        // R4: all lanes contribute together with acc_in
        step(1, 32'h0403_0201, 32'h0807_0605, 1, 1, 32'h0001_0000, "R4");
        // R5: wrap past the top and below zero
        step(1, 32'h0000_00FF, 32'h0000_00FF, 0, 0, 32'hFFFF_FFF0, "R5");
        step(1, 32'h0000_0001, 32'h0000_00FF, 0, 1, 32'h0000_0000, "R5");
        // R10: unsigned all-0xFF and signed all-0x80 corners
        step(1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 32'd7, "R10");
        step(1, 32'h8080_8080, 32'h8080_8080, 1, 1, 32'd7, "R10");
        // R10: mixed-sign corners for completeness
        step(1, 32'h8080_8080, 32'hFFFF_FFFF, 1, 0, 32'd0, "R10");
        step(1, 32'hFFFF_FFFF, 32'h8080_8080, 0, 1, 32'd0, "R10");
        drain();

        // R8: invalid cycles with changing data leave the output alone
        for (int i = 0; i < 6; i++) step(0, $urandom(), $urandom(), i[0], i[1], $urandom(), "R8");

        // R7: back-to-back random operations with modes changing, some bubbles
        for (int i = 0; i < 3000; i++)
            step(($urandom() % 8) != 0, $urandom(), $urandom(), $urandom() % 2,
                 $urandom() % 2, $urandom(), "R7");

        // R9: reset with the pipeline full discards in-flight operations
        step(1, $urandom(), $urandom(), 1, 0, $urandom(), "R9");
        step(1, $urandom(), $urandom(), 0, 1, $urandom(), "R9");
        apply_reset("R9");
        drain();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #400000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule